// File: doc/BRIEF.md
# Per-Bank Transfer Quota Limiter

This block sits between a DMA write master and the per-bank arbiters of a four-bank on-chip SRAM that the master reaches directly. It keeps a run length for each bank, counting the consecutive 32-bit transfers the master is granted there. When the run hits the bank's quota and another master is waiting for that bank, the block pulls the DMA request to that bank low. The request stays low until the other master reports that its transfer has finished.

A 32-bit configuration register holds one 4-bit quota value per bank. A quota value N other than zero allows 4*N transfers in a run. A value of zero never forces the master to yield. If nobody else is waiting when the quota runs out, the master keeps the bank and a fresh run starts. A newly written quota is copied into a bank's active copy only when that bank's run counter clears, so a run already under way keeps the limit it started with.

Top module: `bank_quota_limiter`

## Requirements
- R1: After reset the configuration register reads 0x0F0F0F0F, and every gated request is low while its DMA request is low.
- R2: The quota value of bank b sits at register bits [8*b+3 : 8*b]. All other bits read as zero whatever was written to them. A write takes effect on the read port the cycle after it.
- R3: While a bank is not yielding, its gated request equals its DMA request.
- R4: With an active quota N other than zero, the gated request of a bank stays high through 4*N-1 consecutive grants. If the other master is requesting that bank when the 4*N-th grant is taken, the gated request is low from the next cycle on.
- R5: A yielding bank keeps its gated request low until an other-master-done pulse is sampled. The gated request follows the DMA request again in the next cycle.
- R6: With an active quota of zero, a bank never yields, whatever number of grants it takes and whether or not another master is requesting.
- R7: If no other master is requesting when the 4*N-th grant is taken, the bank does not yield and its run count restarts from zero. A later yield then needs another 4*N grants.
- R8: A cycle in which the DMA request to a bank is low and no grant occurs clears that bank's run count.
- R9: A new quota value is copied into a bank's active quota only when that bank's run count clears (a release, a quota restart, or the start or end of a yield), never in the middle of a run.
- R10: Banks are independent: a yield in one bank leaves the gated requests of the other banks equal to their DMA requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration register read value |
| dmaReq | input | 4 | DMA master request, one bit per bank |
| dmaGnt | input | 4 | DMA transfer granted this cycle, one bit per bank |
| otherReq | input | 4 | Another master is requesting the bank |
| otherDone | input | 4 | The other master has finished its transfer (one-cycle pulse) |
| gatedReq | output | 4 | DMA request passed on to the bank arbiter |

## Verification
A run counter that is off by one makes the gated request drop one grant early or one grant late. This shows at the port in the cycle right after the 4*N-th grant, so every quota from 0 to 15 is swept on every bank, with and without a competing master. A yield flag that is stuck set or that clears too early shows in the first cycle after the quota is reached, or in the cycle after the done pulse. An active quota that is reloaded at the wrong moment moves the yield point of the next run, and the mid-run write and release sequences expose this within one run of grants.

// File: rtl/quota_pkg.sv
package quota_pkg;
  parameter int NUM_BANKS    = 4;
  parameter int FIELD_W      = 4;
  parameter int FIELD_STRIDE = 8;
  parameter int QUOTA_SHIFT  = 2;
  localparam int CFG_W = NUM_BANKS * FIELD_STRIDE;
  localparam int CNT_W = FIELD_W + QUOTA_SHIFT;

  // Bits that carry a quota value; every other bit is reserved.
  function automatic logic [CFG_W-1:0] fieldMask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      m[b*FIELD_STRIDE +: FIELD_W] = '1;
    end
    return m;
  endfunction

  localparam logic [CFG_W-1:0] FIELD_MASK = fieldMask();
  // Every quota value resets to all ones.
  localparam logic [CFG_W-1:0] RESET_CFG  = FIELD_MASK;

  typedef struct packed {
    logic [NUM_BANKS-1:0] cntInc;
    logic [NUM_BANKS-1:0] cntClr;
  } quota_strobe_t;
endpackage

// File: rtl/quota_datapath.sv
module quota_datapath
  import quota_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [CFG_W-1:0]              cfgWrData,
  output logic [CFG_W-1:0]              cfgRdData,
  input  quota_strobe_t                 strobe,
  output logic [NUM_BANKS-1:0]          quotaLast,
  output logic [NUM_BANKS*FIELD_W-1:0]  actQFlat,
  output logic [NUM_BANKS*CNT_W-1:0]    cntFlat
);
  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= RESET_CFG;
    else if (cfgWrEn) cfgReg <= cfgWrData & FIELD_MASK;
  end

  assign cfgRdData = cfgReg;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [FIELD_W-1:0] actQ;
    logic [FIELD_W-1:0] fieldVal;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cntNext;
    logic [CNT_W-1:0]   limit;

    assign fieldVal = cfgReg[gb*FIELD_STRIDE +: FIELD_W];
    assign cntNext  = cnt + 1'b1;
    assign limit    = {actQ, {QUOTA_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt  <= '0;
        actQ <= '1;
      end else if (strobe.cntClr[gb]) begin
        cnt  <= '0;
        actQ <= fieldVal;
      end else if (strobe.cntInc[gb]) begin
        cnt  <= cntNext;
      end
    end

    assign quotaLast[gb]                     = (actQ != '0) && (cntNext == limit);
    assign actQFlat[gb*FIELD_W +: FIELD_W]   = actQ;
    assign cntFlat[gb*CNT_W +: CNT_W]        = cnt;
  end
endmodule

// File: rtl/quota_control.sv
module quota_control
  import quota_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] dmaReq,
  input  logic [NUM_BANKS-1:0] dmaGnt,
  input  logic [NUM_BANKS-1:0] otherReq,
  input  logic [NUM_BANKS-1:0] otherDone,
  input  logic [NUM_BANKS-1:0] quotaLast,
  output quota_strobe_t        strobe,
  output logic [NUM_BANKS-1:0] yieldVec,
  output logic [NUM_BANKS-1:0] gatedReq
);
  logic [NUM_BANKS-1:0] incVec;
  logic [NUM_BANKS-1:0] clrVec;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic yieldQ;
    logic yieldD;
    logic incB;
    logic clrB;

    always_comb begin
      yieldD = yieldQ;
      incB   = 1'b0;
      clrB   = 1'b0;
      if (yieldQ) begin
        if (otherDone[gb]) begin
          yieldD = 1'b0;
          clrB   = 1'b1;
        end
      end else if (dmaGnt[gb]) begin
        if (quotaLast[gb]) begin
          clrB   = 1'b1;
          yieldD = otherReq[gb];
        end else begin
          incB   = 1'b1;
        end
      end else if (!dmaReq[gb]) begin
        clrB = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) yieldQ <= 1'b0;
      else       yieldQ <= yieldD;
    end

    assign incVec[gb]   = incB;
    assign clrVec[gb]   = clrB;
    assign yieldVec[gb] = yieldQ;
    assign gatedReq[gb] = dmaReq[gb] & ~yieldQ;
  end

  assign strobe = '{cntInc: incVec, cntClr: clrVec};
endmodule

// File: rtl/bank_quota_limiter.sv
module bank_quota_limiter
  import quota_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  output logic [CFG_W-1:0]     cfgRdData,
  input  logic [NUM_BANKS-1:0] dmaReq,
  input  logic [NUM_BANKS-1:0] dmaGnt,
  input  logic [NUM_BANKS-1:0] otherReq,
  input  logic [NUM_BANKS-1:0] otherDone,
  output logic [NUM_BANKS-1:0] gatedReq
);
  quota_strobe_t                 strobe;
  logic [NUM_BANKS-1:0]          quotaLast;
  logic [NUM_BANKS-1:0]          yieldVec;
  logic [NUM_BANKS*FIELD_W-1:0]  actQFlat;
  logic [NUM_BANKS*CNT_W-1:0]    cntFlat;

  quota_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .strobe    (strobe),
    .quotaLast (quotaLast),
    .actQFlat  (actQFlat),
    .cntFlat   (cntFlat)
  );

  quota_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .dmaReq    (dmaReq),
    .dmaGnt    (dmaGnt),
    .otherReq  (otherReq),
    .otherDone (otherDone),
    .quotaLast (quotaLast),
    .strobe    (strobe),
    .yieldVec  (yieldVec),
    .gatedReq  (gatedReq)
  );
endmodule

// File: rtl/quota_limiter_checker.sv
module quota_limiter_checker
  import quota_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgWrEn,
  input logic [CFG_W-1:0]              cfgWrData,
  input logic [CFG_W-1:0]              cfgRdData,
  input logic [NUM_BANKS-1:0]          dmaGnt,
  input logic [NUM_BANKS-1:0]          otherReq,
  input logic [NUM_BANKS-1:0]          otherDone,
  input logic [NUM_BANKS-1:0]          gatedReq,
  input logic [NUM_BANKS-1:0]          yieldVec,
  input logic [NUM_BANKS*FIELD_W-1:0]  actQFlat,
  input logic [NUM_BANKS*CNT_W-1:0]    cntFlat
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~FIELD_MASK) == '0);

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == ($past(cfgWrData) & FIELD_MASK));

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [FIELD_W-1:0] aq;
    logic [CNT_W-1:0]   cn;
    assign aq = actQFlat[gb*FIELD_W +: FIELD_W];
    assign cn = cntFlat[gb*CNT_W +: CNT_W];

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
      (aq != '0) |-> (cn < {aq, {QUOTA_SHIFT{1'b0}}}));

    p_enter_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(yieldVec[gb]) |-> ($past(otherReq[gb]) && $past(dmaGnt[gb])));

    p_yield_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
      (yieldVec[gb] && !otherDone[gb]) |=> !gatedReq[gb]);

    p_yield_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
      (yieldVec[gb] && otherDone[gb]) |=> !yieldVec[gb]);

    p_unlimited_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!yieldVec[gb] && aq == '0) |=> !yieldVec[gb]);
  end
endmodule

bind bank_quota_limiter quota_limiter_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .dmaGnt    (dmaGnt),
  .otherReq  (otherReq),
  .otherDone (otherDone),
  .gatedReq  (gatedReq),
  .yieldVec  (yieldVec),
  .actQFlat  (actQFlat),
  .cntFlat   (cntFlat)
);

// File: tb/bank_quota_limiter_tb.sv
`timescale 1ns/1ps
module bank_quota_limiter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [3:0]  dmaReq = '0;
  logic [3:0]  dmaGnt = '0;
  logic [3:0]  otherReq = '0;
  logic [3:0]  otherDone = '0;
  logic [3:0]  gatedReq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bank_quota_limiter u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .dmaReq(dmaReq), .dmaGnt(dmaGnt),
    .otherReq(otherReq), .otherDone(otherDone), .gatedReq(gatedReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=<190000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkGate(input int b, input bit exp, input string req);
    check(gatedReq[b] == exp, req, 32'(gatedReq[b]), 32'(exp));
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic grantN(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dmaReq[b] = 1'b1; dmaGnt[b] = 1'b1;
    end
    @(negedge clk); dmaGnt[b] = 1'b0;
  endtask

  task automatic releaseBank(input int b);
    @(negedge clk); dmaReq[b] = 1'b0; dmaGnt[b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseDone(input int b);
    @(negedge clk); otherDone[b] = 1'b1;
    @(negedge clk); otherDone[b] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfgRdData == 32'h0F0F0F0F, "R1 reset value", cfgRdData, 32'h0F0F0F0F);
    check(gatedReq == 4'h0, "R1 idle gate", 32'(gatedReq), 32'h0);
    // R3 pass-through
    dmaReq = 4'hF; #1;
    check(gatedReq == 4'hF, "R3 pass-through", 32'(gatedReq), 32'hF);
    dmaReq = 4'h0;

    // R2 field layout and reserved bits
    writeCfg(32'hA5A5A5A5);
    check(cfgRdData == 32'h05050505, "R2 reserved zero", cfgRdData, 32'h05050505);
    writeCfg(32'h0C030201);
    check(cfgRdData == 32'h0C030201, "R2 field positions", cfgRdData, 32'h0C030201);

    // Sweep: every bank, every quota, with and without a competitor (R4 R5 R6 R7 R10)
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 16; n++) begin
        for (int oth = 0; oth < 2; oth++) begin
          writeCfg(32'(n) << (8*b));
          releaseBank(b);
          otherReq[b] = oth[0];
          if (n == 0) begin
            grantN(b, 70);
            checkGate(b, 1'b1, "R6 unlimited run");
          end else begin
            grantN(b, 4*n - 1);
            checkGate(b, 1'b1, "R4 below quota");
            grantN(b, 1);
            if (oth != 0) begin
              checkGate(b, 1'b0, "R4 yield at quota");
              dmaReq = 4'hF; #1;
              check(gatedReq == (4'hF & ~(4'h1 << b)), "R10 other banks unaffected",
                    32'(gatedReq), 32'(4'hF & ~(4'h1 << b)));
              dmaReq = 4'h1 << b;
              repeat (3) @(negedge clk);
              checkGate(b, 1'b0, "R5 hold until done");
              pulseDone(b);
              checkGate(b, 1'b1, "R5 resume after done");
            end else begin
              checkGate(b, 1'b1, "R7 keep idle bank");
              otherReq[b] = 1'b1;
              grantN(b, 4*n - 1);
              checkGate(b, 1'b1, "R7 restarted count");
              grantN(b, 1);
              checkGate(b, 1'b0, "R7 second run limit");
              pulseDone(b);
            end
          end
          otherReq[b] = 1'b0;
          releaseBank(b);
        end
      end
    end

    // R8 release clears the run count
    writeCfg(32'h00000200);
    releaseBank(1);
    otherReq[1] = 1'b1;
    grantN(1, 5);
    releaseBank(1);
    grantN(1, 7);
    checkGate(1, 1'b1, "R8 count cleared by release");
    grantN(1, 1);
    checkGate(1, 1'b0, "R8 yield after full run");
    pulseDone(1);
    otherReq[1] = 1'b0;
    releaseBank(1);

    // R9 mid-run quota write is deferred
    writeCfg(32'h00000002);
    releaseBank(0);
    otherReq[0] = 1'b1;
    grantN(0, 3);
    writeCfg(32'h00000001);
    grantN(0, 4);
    checkGate(0, 1'b1, "R9 old quota kept mid-run");
    grantN(0, 1);
    checkGate(0, 1'b0, "R9 old quota reached");
    pulseDone(0);
    grantN(0, 3);
    checkGate(0, 1'b1, "R9 new quota below");
    grantN(0, 1);
    checkGate(0, 1'b0, "R9 new quota applied");
    pulseDone(0);
    otherReq[0] = 1'b0;
    releaseBank(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule